// File: doc/BRIEF.md
# DDR2 Refresh and Power-State Sequencer

This block sits beside the command arbiter of a DDR2 memory controller. It times the periodic auto-refresh and keeps count of the refreshes that are owed. It drives the clock-enable pin for self-refresh and power-down. After each refresh and after each low-power exit, it tells the arbiter when reads, non-read commands and refreshes may be issued again.

Refresh slots are counted in clock cycles. The slot interval is halved while the high-temperature flag is set. Up to eight refreshes may be postponed. A ninth owed refresh makes the request urgent, and the sequencer then holds back reads and non-read commands until one refresh has been issued. Power-down is entered as precharge power-down when no bank is open, and as active power-down otherwise. The exit delays depend on the mode that was entered. For active power-down they also depend on the fast-exit or slow-exit setting and on the programmed additive latency.

Top module: `ddr_refresh_pwr_seq`

## Requirements
- R1: With `hot_i` low, a refresh slot comes due every TREFI_CYC cycles, and `ref_req_o` is high while at least one refresh is owed.
- R2: With `hot_i` high, a refresh slot comes due every TREFI_CYC/2 cycles.
- R3: A pulse on `ref_done_i` is taken only when `ref_req_o` and `ref_ready_o` are both high. A taken refresh removes one owed refresh, and it holds `ref_ready_o` and `nrd_ready_o` low for TRFC_CYC cycles. A pulse that is not taken has no effect.
- R4: While MAX_POSTPONE or fewer refreshes are owed, `ref_urgent_o` stays low. When one more slot comes due it goes high, and it holds `rd_ready_o` and `nrd_ready_o` low until one refresh is taken.
- R5: Self-refresh is entered (`cke_o` low) only on `sr_req_i` with `bank_open_i` low, while no refresh is in progress. A self-refresh request while a bank is open is ignored. Self-refresh clears the owed refreshes and freezes the slot timer, so `ref_req_o` stays low during self-refresh.
- R6: After self-refresh exit, `nrd_ready_o` stays low for TXSNR_CYC cycles and `rd_ready_o` for TXSRD_CYC cycles, counted from the first cycle with `cke_o` high.
- R7: After exit from precharge power-down (entered with `bank_open_i` low), both `rd_ready_o` and `nrd_ready_o` stay low for TXP_CYC cycles.
- R8: After exit from active power-down with `slow_exit_i` low, `rd_ready_o` stays low for TXARD_CYC cycles and `nrd_ready_o` for TXP_CYC cycles, whatever `al_i` is.
- R9: After exit from active power-down with `slow_exit_i` high, `rd_ready_o` stays low for SLOW_BASE − `al_i` cycles (zero if `al_i` ≥ SLOW_BASE) and `nrd_ready_o` for TXP_CYC cycles.
- R10: `cke_o` stays at each level for at least TCKE_CYC cycles. A power-down request lasting one cycle gives exactly TCKE_CYC cycles of `cke_o` low.
- R11: After reset, `cke_o`, `rd_ready_o`, `nrd_ready_o` and `ref_ready_o` are high, and `ref_req_o` and `ref_urgent_o` are low. All three ready strobes are low whenever `cke_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hot_i | input | 1 | Case temperature above 85 °C; selects the halved refresh interval |
| sr_req_i | input | 1 | Self-refresh request, level held for the stay |
| pd_req_i | input | 1 | Power-down request, level held for the stay |
| bank_open_i | input | 1 | At least one bank is open |
| slow_exit_i | input | 1 | Active power-down uses slow exit |
| al_i | input | AL_W | Programmed additive latency |
| ref_done_i | input | 1 | Arbiter issues a refresh this cycle |
| ref_req_o | output | 1 | At least one refresh owed |
| ref_urgent_o | output | 1 | Postpone limit exceeded; other traffic blocked |
| cke_o | output | 1 | Clock-enable level for the memory |
| rd_ready_o | output | 1 | Read commands may be issued |
| nrd_ready_o | output | 1 | Non-read commands may be issued |
| ref_ready_o | output | 1 | A refresh may be issued |

## Verification
The refresh timer is run with the cool and the hot interval, with refreshes issued at once, and with refreshes held back until the postpone limit is passed. This separates the interval length from the limit at which the request becomes urgent. The power-down exit is swept over every combination of bank state, exit speed and additive latency from 0 to 5. So a wrong mode capture, a swapped read and non-read delay, or an additive latency that leaks into the fast exit each shows up as a wrong cycle count. Self-refresh is tried first with a bank open, which must be ignored, and then with the banks closed while refreshes are owed. This shows both that the owed count is cleared and that the two longer exit delays are applied.

// File: rtl/ddr_rps_pkg.sv
package ddr_rps_pkg;

  typedef enum logic [1:0] {
    PWR_ON   = 2'd0,
    PWR_SREF = 2'd1,
    PWR_PDN  = 2'd2
  } pwr_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_rps_delay.sv
module ddr_rps_delay #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             idle_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_rps_refresh.sv
module ddr_rps_refresh #(
  parameter int unsigned TREFI_CYC    = 3120,
  parameter int unsigned MAX_POSTPONE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic hold_i,
  input  logic take_i,
  output logic req_o,
  output logic urgent_o
);

  localparam int unsigned TMR_W  = $clog2(TREFI_CYC);
  localparam int unsigned PEND_W = $clog2(MAX_POSTPONE + 2);
  localparam logic [TMR_W-1:0]  RELOAD_COOL = TMR_W'(TREFI_CYC - 1);
  localparam logic [TMR_W-1:0]  RELOAD_HOT  = TMR_W'(TREFI_CYC / 2 - 1);
  localparam logic [PEND_W-1:0] PEND_MAX    = PEND_W'(MAX_POSTPONE + 1);

  logic [TMR_W-1:0]  tmr_q;
  logic [PEND_W-1:0] pend_q;
  logic [TMR_W-1:0]  reload;
  logic              slot_due;
  logic              inc;

  assign reload   = hot_i ? RELOAD_HOT : RELOAD_COOL;
  assign slot_due = (tmr_q == '0);
  assign inc      = slot_due && (pend_q != PEND_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= RELOAD_COOL;
      pend_q <= '0;
    end else if (hold_i) begin
      // self-refresh covers the array; restart the schedule
      tmr_q  <= reload;
      pend_q <= '0;
    end else begin
      tmr_q <= slot_due ? reload : tmr_q - 1'b1;
      case ({inc, take_i})
        2'b10:   pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign req_o    = (pend_q != '0);
  assign urgent_o = (pend_q == PEND_MAX);

endmodule

// File: rtl/ddr_rps_pwr.sv
module ddr_rps_pwr
  import ddr_rps_pkg::*;
#(
  parameter int unsigned TCKE_CYC  = 3,
  parameter int unsigned TXSNR_CYC = 55,
  parameter int unsigned TXSRD_CYC = 200,
  parameter int unsigned TXP_CYC   = 2,
  parameter int unsigned TXARD_CYC = 2,
  parameter int unsigned SLOW_BASE = 8,
  parameter int unsigned AL_W      = 3,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sr_req_i,
  input  logic             pd_req_i,
  input  logic             bank_open_i,
  input  logic             slow_exit_i,
  input  logic [AL_W-1:0]  al_i,
  input  logic             quiet_i,
  output pwr_state_e       state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] rd_val_o,
  output logic [CNT_W-1:0] nrd_val_o
);

  localparam int unsigned HOLD_W = $clog2(TCKE_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(TCKE_CYC - 1);
  localparam logic [CNT_W-1:0]  SLOW_V    = CNT_W'(SLOW_BASE);

  pwr_state_e        state_q, state_d;
  logic [HOLD_W-1:0] hold_q;
  logic              act_pd_q;
  logic              can_move;
  logic [CNT_W-1:0]  al_c;
  logic [CNT_W-1:0]  slow_rd;

  assign can_move = (hold_q == '0);
  assign al_c     = CNT_W'(al_i);
  assign slow_rd  = (al_c >= SLOW_V) ? '0 : SLOW_V - al_c;

  always_comb begin
    state_d   = state_q;
    load_o    = 1'b0;
    rd_val_o  = '0;
    nrd_val_o = '0;
    unique case (state_q)
      PWR_ON: begin
        if (can_move && quiet_i) begin
          if (sr_req_i) begin
            if (!bank_open_i) state_d = PWR_SREF;
            else if (pd_req_i) state_d = PWR_PDN;
          end else if (pd_req_i) begin
            state_d = PWR_PDN;
          end
        end
      end
      PWR_SREF: begin
        if (can_move && !sr_req_i) begin
          state_d   = PWR_ON;
          load_o    = 1'b1;
          rd_val_o  = CNT_W'(TXSRD_CYC);
          nrd_val_o = CNT_W'(TXSNR_CYC);
        end
      end
      PWR_PDN: begin
        if (can_move && !pd_req_i) begin
          state_d   = PWR_ON;
          load_o    = 1'b1;
          nrd_val_o = CNT_W'(TXP_CYC);
          if (!act_pd_q)        rd_val_o = CNT_W'(TXP_CYC);
          else if (slow_exit_i) rd_val_o = slow_rd;
          else                  rd_val_o = CNT_W'(TXARD_CYC);
        end
      end
      default: state_d = PWR_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PWR_ON;
      hold_q   <= '0;
      act_pd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) hold_q <= HOLD_INIT;
      else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
      if (state_q == PWR_ON && state_d == PWR_PDN) act_pd_q <= bank_open_i;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/ddr_refresh_pwr_seq.sv
module ddr_refresh_pwr_seq
  import ddr_rps_pkg::*;
#(
  parameter int unsigned TREFI_CYC    = 3120,
  parameter int unsigned TRFC_CYC     = 51,
  parameter int unsigned TXSNR_CYC    = 55,
  parameter int unsigned TXSRD_CYC    = 200,
  parameter int unsigned TXP_CYC      = 2,
  parameter int unsigned TXARD_CYC    = 2,
  parameter int unsigned SLOW_BASE    = 8,
  parameter int unsigned TCKE_CYC     = 3,
  parameter int unsigned MAX_POSTPONE = 8,
  parameter int unsigned AL_W         = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hot_i,
  input  logic            sr_req_i,
  input  logic            pd_req_i,
  input  logic            bank_open_i,
  input  logic            slow_exit_i,
  input  logic [AL_W-1:0] al_i,
  input  logic            ref_done_i,
  output logic            ref_req_o,
  output logic            ref_urgent_o,
  output logic            cke_o,
  output logic            rd_ready_o,
  output logic            nrd_ready_o,
  output logic            ref_ready_o
);

  localparam int unsigned DLY_MAX = max2(max2(max2(TXSNR_CYC, TXSRD_CYC), max2(TXP_CYC, TXARD_CYC)),
                                         max2(TRFC_CYC, SLOW_BASE));
  localparam int unsigned CNT_W   = $clog2(DLY_MAX + 1);
  localparam int unsigned N_DLY   = 3;
  localparam int unsigned D_RD    = 0;
  localparam int unsigned D_NRD   = 1;
  localparam int unsigned D_RFC   = 2;

  pwr_state_e       state;
  logic             exit_load;
  logic [CNT_W-1:0] exit_rd_val, exit_nrd_val;
  logic             ref_take;
  logic             quiet;
  logic             dly_load [N_DLY];
  logic [CNT_W-1:0] dly_val  [N_DLY];
  logic             dly_idle [N_DLY];

  assign ref_take = ref_done_i && ref_req_o && ref_ready_o;
  assign quiet    = dly_idle[D_RFC] && !ref_take && !ref_urgent_o;

  ddr_rps_refresh #(
    .TREFI_CYC   (TREFI_CYC),
    .MAX_POSTPONE(MAX_POSTPONE)
  ) u_refresh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hot_i   (hot_i),
    .hold_i  (state == PWR_SREF),
    .take_i  (ref_take),
    .req_o   (ref_req_o),
    .urgent_o(ref_urgent_o)
  );

  ddr_rps_pwr #(
    .TCKE_CYC (TCKE_CYC),
    .TXSNR_CYC(TXSNR_CYC),
    .TXSRD_CYC(TXSRD_CYC),
    .TXP_CYC  (TXP_CYC),
    .TXARD_CYC(TXARD_CYC),
    .SLOW_BASE(SLOW_BASE),
    .AL_W     (AL_W),
    .CNT_W    (CNT_W)
  ) u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sr_req_i   (sr_req_i),
    .pd_req_i   (pd_req_i),
    .bank_open_i(bank_open_i),
    .slow_exit_i(slow_exit_i),
    .al_i       (al_i),
    .quiet_i    (quiet),
    .state_o    (state),
    .load_o     (exit_load),
    .rd_val_o   (exit_rd_val),
    .nrd_val_o  (exit_nrd_val)
  );

  assign dly_load[D_RD]  = exit_load;
  assign dly_val[D_RD]   = exit_rd_val;
  assign dly_load[D_NRD] = exit_load;
  assign dly_val[D_NRD]  = exit_nrd_val;
  assign dly_load[D_RFC] = ref_take;
  assign dly_val[D_RFC]  = CNT_W'(TRFC_CYC);

  for (genvar g = 0; g < N_DLY; g++) begin : g_dly
    ddr_rps_delay #(.CNT_W(CNT_W)) u_dly (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(dly_load[g]),
      .val_i (dly_val[g]),
      .idle_o(dly_idle[g])
    );
  end

  assign cke_o       = (state == PWR_ON);
  assign rd_ready_o  = cke_o && dly_idle[D_RD] && !ref_urgent_o;
  assign nrd_ready_o = cke_o && dly_idle[D_NRD] && dly_idle[D_RFC] && !ref_urgent_o;
  assign ref_ready_o = cke_o && dly_idle[D_NRD] && dly_idle[D_RFC];

endmodule

// File: rtl/ddr_rps_checker.sv
module ddr_rps_checker #(
  parameter int unsigned TCKE_CYC = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pd_req_i,
  input logic bank_open_i,
  input logic ref_done_i,
  input logic ref_req_o,
  input logic ref_urgent_o,
  input logic cke_o,
  input logic rd_ready_o,
  input logic nrd_ready_o,
  input logic ref_ready_o
);

  localparam int unsigned LW = $clog2(TCKE_CYC + 2);
  logic          cke_q;
  logic [LW-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q <= 1'b1;
      lvl_q <= LW'(TCKE_CYC);
    end else begin
      cke_q <= cke_o;
      if (cke_o != cke_q)              lvl_q <= LW'(1);
      else if (lvl_q < LW'(TCKE_CYC))  lvl_q <= lvl_q + 1'b1;
    end
  end

  assert_cke_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o != cke_q) |-> (lvl_q >= LW'(TCKE_CYC)));

  assert_low_cke_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (!rd_ready_o && !nrd_ready_o && !ref_ready_o));

  assert_urgent_has_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_urgent_o |-> ref_req_o);

  assert_urgent_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_urgent_o |-> (!rd_ready_o && !nrd_ready_o));

  assert_trfc_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_done_i && ref_req_o && ref_ready_o) |=> (!ref_ready_o && !nrd_ready_o));

  assert_sr_banks_closed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cke_o) && $past(bank_open_i)) |-> $past(pd_req_i));

endmodule

bind ddr_refresh_pwr_seq ddr_rps_checker #(.TCKE_CYC(TCKE_CYC)) u_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pd_req_i    (pd_req_i),
  .bank_open_i (bank_open_i),
  .ref_done_i  (ref_done_i),
  .ref_req_o   (ref_req_o),
  .ref_urgent_o(ref_urgent_o),
  .cke_o       (cke_o),
  .rd_ready_o  (rd_ready_o),
  .nrd_ready_o (nrd_ready_o),
  .ref_ready_o (ref_ready_o)
);

// File: tb/ddr_refresh_pwr_seq_bench.sv
`timescale 1ns/1ps
module ddr_refresh_pwr_seq_bench;

  localparam int TREFI = 40, TRFC = 6, TXSNR = 9, TXSRD = 20, TXP = 3, TXARD = 2;
  localparam int SLOWB = 8, TCKE = 3, MAXP = 8, ALW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hot = 0, sr_req = 0, pd_req = 0, bank_open = 0, slow_exit = 0, ref_done = 0;
  logic [ALW-1:0] al = '0;
  logic ref_req, ref_urgent, cke, rd_ready, nrd_ready, ref_ready;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_refresh_pwr_seq #(
    .TREFI_CYC(TREFI), .TRFC_CYC(TRFC), .TXSNR_CYC(TXSNR), .TXSRD_CYC(TXSRD),
    .TXP_CYC(TXP), .TXARD_CYC(TXARD), .SLOW_BASE(SLOWB), .TCKE_CYC(TCKE),
    .MAX_POSTPONE(MAXP), .AL_W(ALW)
  ) u_ddr_refresh_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .hot_i(hot), .sr_req_i(sr_req), .pd_req_i(pd_req),
    .bank_open_i(bank_open), .slow_exit_i(slow_exit), .al_i(al), .ref_done_i(ref_done),
    .ref_req_o(ref_req), .ref_urgent_o(ref_urgent), .cke_o(cke), .rd_ready_o(rd_ready),
    .nrd_ready_o(nrd_ready), .ref_ready_o(ref_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int at);
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      if (ref_req) begin at = cyc; break; end
      @(negedge clk);
    end
  endtask

  task automatic issue_ref();
    ref_done = 1'b1;
    @(negedge clk);
    ref_done = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 1000; i++) begin
      if (!ref_req && ref_ready && rd_ready && nrd_ready) break;
      if (ref_req && ref_ready) issue_ref();
      else @(negedge clk);
    end
    repeat (TCKE + 1) @(negedge clk);
  endtask

  task automatic measure_exit(output int n_rd, output int n_nrd);
    n_rd = -1; n_nrd = -1;
    for (int i = 0; i < 400 && !cke; i++) @(negedge clk);
    for (int k = 0; k < 400; k++) begin
      if (n_rd < 0 && rd_ready) n_rd = k;
      if (n_nrd < 0 && nrd_ready) n_nrd = k;
      if (n_rd >= 0 && n_nrd >= 0) break;
      @(negedge clk);
    end
  endtask

  task automatic pd_case(input bit bo, input bit sl, input int a);
    int low, n_rd, n_nrd, e_rd;
    drain();
    bank_open = bo; slow_exit = sl; al = ALW'(a);
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    low = 0;
    for (int i = 0; i < 50 && !cke; i++) begin low++; @(negedge clk); end
    chk(low == TCKE, "R10 cke low time", low, TCKE);
    measure_exit(n_rd, n_nrd);
    if (!bo)      e_rd = TXP;
    else if (sl)  e_rd = (a >= SLOWB) ? 0 : SLOWB - a;
    else          e_rd = TXARD;
    if (!bo)      chk(n_rd == e_rd, "R7 precharge pd read delay", n_rd, e_rd);
    else if (sl)  chk(n_rd == e_rd, "R9 slow active pd read delay", n_rd, e_rd);
    else          chk(n_rd == e_rd, "R8 fast active pd read delay", n_rd, e_rd);
    chk(n_nrd == TXP, bo ? "R8 active pd non-read delay" : "R7 precharge pd non-read delay",
        n_nrd, TXP);
    bank_open = 1'b0;
  endtask

  initial begin
    int t0, t1, n, n_rd, n_nrd, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(cke == 1, "R11 cke after reset", cke, 1);
    chk(rd_ready == 1, "R11 rd_ready after reset", rd_ready, 1);
    chk(nrd_ready == 1, "R11 nrd_ready after reset", nrd_ready, 1);
    chk(ref_ready == 1, "R11 ref_ready after reset", ref_ready, 1);
    chk(ref_req == 0 && ref_urgent == 0, "R11 req/urgent after reset", ref_req + ref_urgent, 0);

    // R3 ignored pulse when nothing owed
    ref_done = 1'b1; @(negedge clk); ref_done = 1'b0;
    chk(ref_ready == 1, "R3 ignored ref_done keeps ref_ready", ref_ready, 1);

    // R1 cool interval
    wait_rise(t0); issue_ref();
    chk(ref_req == 0, "R3 taken refresh clears request", ref_req, 0);
    n = 0;
    for (int i = 0; i < 50 && !ref_ready; i++) begin n++; @(negedge clk); end
    chk(n == TRFC, "R3 ref_ready low for tRFC", n, TRFC);
    wait_rise(t1);
    chk(t1 - t0 == TREFI, "R1 cool refresh interval", t1 - t0, TREFI);
    issue_ref();

    // R3 nrd blocked during tRFC, read unaffected
    wait_rise(t0); issue_ref();
    n = 0;
    for (int i = 0; i < 50 && !nrd_ready; i++) begin
      if (!rd_ready) bad = 1;
      n++; @(negedge clk);
    end
    chk(n == TRFC, "R3 nrd_ready low for tRFC", n, TRFC);

    // R2 hot interval
    hot = 1'b1;
    wait_rise(t0); issue_ref();
    wait_rise(t0); issue_ref();
    wait_rise(t1);
    chk(t1 - t0 == TREFI / 2, "R2 hot refresh interval", t1 - t0, TREFI / 2);
    hot = 1'b0;
    drain();

    // R4 postpone limit
    wait_rise(t0);
    while (cyc < t0 + MAXP * TREFI - 1) @(negedge clk);
    chk(ref_urgent == 0, "R4 not urgent with limit owed", ref_urgent, 0);
    @(negedge clk);
    chk(ref_urgent == 1, "R4 urgent after limit exceeded", ref_urgent, 1);
    chk(rd_ready == 0 && nrd_ready == 0, "R4 urgent blocks traffic", rd_ready + nrd_ready, 0);
    issue_ref();
    chk(ref_urgent == 0, "R4 one refresh clears urgency", ref_urgent, 0);
    chk(rd_ready == 1, "R4 read ready after urgency cleared", rd_ready, 1);
    drain();

    // R5 self-refresh ignored with open bank, then entered with refreshes owed
    wait_rise(t0);
    bank_open = 1'b1; sr_req = 1'b1;
    repeat (5) @(negedge clk);
    chk(cke == 1, "R5 self-refresh ignored with bank open", cke, 1);
    bank_open = 1'b0;
    @(negedge clk);
    chk(cke == 0, "R5 self-refresh entered", cke, 0);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 3 * TREFI; i++) begin
      if (ref_req) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R5 no refresh request in self-refresh", bad, 0);
    sr_req = 1'b0;
    measure_exit(n_rd, n_nrd);
    chk(n_nrd == TXSNR, "R6 self-refresh non-read delay", n_nrd, TXSNR);
    chk(n_rd == TXSRD, "R6 self-refresh read delay", n_rd, TXSRD);

    // R7 R8 R9 power-down exit sweep
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 6; a++)
          pd_case(b[0], s[0], a);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule